// File: doc/BRIEF.md
# Slave Address-Modifier and Window Decoder

This block decides whether one slave memory port on a VMEbus-style backplane claims a bus cycle. When a cycle begins, it takes the 6-bit address modifier, the 32-bit address, a lower and an upper page limit, and a port-disable control bit. It classifies the modifier into a cycle class and an address width. It compares the address against a window set in 1 Mbyte pages. From these it produces a registered select.

When the claimed cycle is a block transfer, the block also tracks the burst. The surrounding bus logic pulses `beat` once for each completed data beat. The block advances its running address by the beat size and counts the bytes moved. It raises a sticky error flag when a further beat would carry the burst past its allowed length: 256 bytes for ordinary block transfers and 2 Kbytes for multiplexed 64-bit transfers. The handshake, memory control and data paths sit outside this block and consume `sel`, `cls`, `a32`, `cur_addr` and `burst_err`.

Top module: `am_window_dec`

## Requirements
- R1: Modifiers 0x38..0x3F are accepted with `a32`=0. The low three bits select the class: 1, 2, 5 and 6 give single (`cls`=1), 3 and 7 give block (`cls`=2), and 0 and 4 give multiplexed 64-bit block (`cls`=3).
- R2: Modifiers 0x08..0x0F are accepted with `a32`=1, using the same class mapping on the low three bits as R1.
- R3: Any other modifier gives `cls`=0 and leaves `sel` low, whatever the address.
- R4: Address bits [31:20] form the page number. `sel` requires `lo_lim` <= page < `hi_lim`, so the lower limit is inclusive and the upper limit is exclusive.
- R5: For an A24 cycle, address bits [31:24] are taken as zero before the window test and in `cur_addr`.
- R6: While `port_dis` is 1, `sel` is 0 from the next cycle on, beats are ignored, and `sel` stays low until a new cycle start.
- R7: Each accepted beat of a claimed block advances `cur_addr` by 4 (`cls`=2) or by 8 (`cls`=3). `cur_addr` starts at the cycle's address.
- R8: An ordinary block accepts 64 beats (256 bytes). The 65th beat sets `burst_err` and leaves `cur_addr` unchanged.
- R9: A multiplexed 64-bit block accepts 256 beats (2 Kbytes). The 257th beat sets `burst_err` and leaves `cur_addr` unchanged.
- R10: `burst_err` holds until the next `cyc_start`, which clears it and restarts the byte count. A `cyc_start` in the same cycle as `beat` takes priority over the beat.
- R11: Beats during a single cycle or an unclaimed cycle leave `cur_addr` and `burst_err` unchanged.
- R12: `sel`, `cls`, `a32` and `cur_addr` update on the clock edge that samples `cyc_start`, and they hold between starts. After reset, `sel`=0, `cls`=0 and `burst_err`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Samples am/addr as a new bus cycle |
| am | input | 6 | Address modifier |
| addr | input | 32 | Bus address |
| lo_lim | input | 12 | Lower page limit (inclusive, 1 Mbyte units) |
| hi_lim | input | 12 | Upper page limit (exclusive, 1 Mbyte units) |
| port_dis | input | 1 | Control bit forcing the port off |
| beat | input | 1 | One data beat of the current cycle completed |
| sel | output | 1 | Port claims the current cycle |
| cls | output | 2 | Cycle class: 0 none, 1 single, 2 block, 3 multiplexed block |
| a32 | output | 1 | 1 for 32-bit space, 0 for 24-bit space |
| cur_addr | output | 32 | Running address of the current cycle |
| burst_err | output | 1 | Burst would pass its allowed length |

## Verification
Two of the block's functions can fall in the same cycle. The first pair is a new cycle start and a beat of the running burst: the bench drives `cyc_start` and `beat` together partway through a block. It expects `cur_addr` to equal the new address and `burst_err` to be clear, which shows that the start won and the count restarted. The second pair is the port-disable bit and beats arriving together. The bench raises `port_dis` mid-burst while it keeps beating. It judges the case by `sel` falling and `cur_addr` freezing at the value reached before the disable.

// File: rtl/amw_pkg.sv
package amw_pkg;
  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_SINGLE = 2'd1,
    CLS_BLOCK  = 2'd2,
    CLS_MBLK   = 2'd3
  } cyc_cls_e;
endpackage

// File: rtl/amw_am_decode.sv
module amw_am_decode
  import amw_pkg::*;
(
  input  logic [5:0] am,
  output logic       valid,
  output cyc_cls_e   cls,
  output logic       a32
);
  logic grp24, grp32;

  always_comb begin
    grp24 = (am[5:3] == 3'b111);
    grp32 = (am[5:3] == 3'b001);
    valid = grp24 | grp32;
    a32   = grp32;
    cls   = CLS_NONE;
    if (valid) begin
      case (am[2:0])
        3'd0, 3'd4: cls = CLS_MBLK;
        3'd3, 3'd7: cls = CLS_BLOCK;
        default:    cls = CLS_SINGLE;
      endcase
    end
  end
endmodule

// File: rtl/amw_window_cmp.sv
module amw_window_cmp #(
  parameter int AW       = 32,
  parameter int PAGE_LSB = 20,
  parameter int NARROW   = 24
) (
  input  logic [AW-1:0]          addr,
  input  logic                   a32,
  input  logic [AW-PAGE_LSB-1:0] lo_lim,
  input  logic [AW-PAGE_LSB-1:0] hi_lim,
  output logic                   hit,
  output logic [AW-1:0]          eff_addr
);
  localparam int PW = AW - PAGE_LSB;
  logic [PW-1:0] page;

  always_comb begin
    eff_addr = addr;
    if (!a32) eff_addr[AW-1:NARROW] = '0;
    page = eff_addr[AW-1:PAGE_LSB];
    hit  = (page >= lo_lim) && (page < hi_lim);
  end
endmodule

// File: rtl/amw_burst_trk.sv
module amw_burst_trk #(
  parameter int AW         = 32,
  parameter int BLT_BYTES  = 256,
  parameter int MBLT_BYTES = 2048,
  parameter int NARROW_BEAT = 4,
  parameter int WIDE_BEAT   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_blk,
  input  logic          start_wide,
  input  logic [AW-1:0] start_addr,
  input  logic          abort,
  input  logic          beat,
  output logic [AW-1:0] cur_addr,
  output logic          err
);
  localparam int MAXB = (MBLT_BYTES > BLT_BYTES) ? MBLT_BYTES : BLT_BYTES;
  localparam int CW   = $clog2(MAXB + WIDE_BEAT) + 1;

  logic          act_q, act_d;
  logic          wide_q, wide_d;
  logic          err_q, err_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] base_q, base_d;
  logic [CW-1:0] step, limit, cnt_nxt;

  always_comb begin
    step    = wide_q ? CW'(WIDE_BEAT) : CW'(NARROW_BEAT);
    limit   = wide_q ? CW'(MBLT_BYTES) : CW'(BLT_BYTES);
    cnt_nxt = cnt_q + step;
    act_d   = act_q;
    wide_d  = wide_q;
    err_d   = err_q;
    cnt_d   = cnt_q;
    base_d  = base_q;
    if (start) begin
      act_d  = start_blk;
      wide_d = start_wide;
      err_d  = 1'b0;
      cnt_d  = '0;
      base_d = start_addr;
    end else if (abort) begin
      act_d = 1'b0;
    end else if (beat && act_q) begin
      if (cnt_nxt <= limit) cnt_d = cnt_nxt;
      else                  err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wide_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      act_q  <= act_d;
      wide_q <= wide_d;
      err_q  <= err_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
    end
  end

  assign cur_addr = base_q + AW'(cnt_q);
  assign err      = err_q;

  // R8
  cnt_within_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !start) |=> err_q);
  // R11
  idle_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/am_window_dec.sv
module am_window_dec
  import amw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PAGE_LSB   = 20,
  parameter int NARROW     = 24,
  parameter int BLT_BYTES  = 256,
  parameter int MBLT_BYTES = 2048
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cyc_start,
  input  logic [5:0]             am,
  input  logic [AW-1:0]          addr,
  input  logic [AW-PAGE_LSB-1:0] lo_lim,
  input  logic [AW-PAGE_LSB-1:0] hi_lim,
  input  logic                   port_dis,
  input  logic                   beat,
  output logic                   sel,
  output logic [1:0]             cls,
  output logic                   a32,
  output logic [AW-1:0]          cur_addr,
  output logic                   burst_err
);
  logic          am_ok, am_a32, win_hit, claim;
  cyc_cls_e      am_cls;
  logic [AW-1:0] eff_addr;
  logic          sel_q, sel_d, a32_q, a32_d;
  cyc_cls_e      cls_q, cls_d;

  amw_am_decode u_dec (
    .am    (am),
    .valid (am_ok),
    .cls   (am_cls),
    .a32   (am_a32)
  );

  amw_window_cmp #(.AW(AW), .PAGE_LSB(PAGE_LSB), .NARROW(NARROW)) u_win (
    .addr     (addr),
    .a32      (am_a32),
    .lo_lim   (lo_lim),
    .hi_lim   (hi_lim),
    .hit      (win_hit),
    .eff_addr (eff_addr)
  );

  assign claim = am_ok && win_hit && !port_dis;

  always_comb begin
    sel_d = sel_q;
    cls_d = cls_q;
    a32_d = a32_q;
    if (cyc_start) begin
      sel_d = claim;
      cls_d = am_cls;
      a32_d = am_a32;
    end else if (port_dis) begin
      sel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cls_q <= CLS_NONE;
      a32_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      cls_q <= cls_d;
      a32_q <= a32_d;
    end
  end

  amw_burst_trk #(.AW(AW), .BLT_BYTES(BLT_BYTES), .MBLT_BYTES(MBLT_BYTES)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cyc_start),
    .start_blk  (claim && (am_cls == CLS_BLOCK || am_cls == CLS_MBLK)),
    .start_wide (am_cls == CLS_MBLK),
    .start_addr (eff_addr),
    .abort      (port_dis),
    .beat       (beat),
    .cur_addr   (cur_addr),
    .err        (burst_err)
  );

  assign sel = sel_q;
  assign cls = cls_q;
  assign a32 = a32_q;

  // R6
  dis_blocks_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_dis |=> !sel);
  // R3
  sel_needs_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> (cls != CLS_NONE));
  // R12
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> ($stable(cls) && $stable(a32)));
  // R5
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !a32) |-> (cur_addr[AW-1:NARROW] == '0));
endmodule

// File: tb/sim_am_window_dec.sv
module sim_am_window_dec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_start, port_dis, beat;
  logic [5:0]  am;
  logic [31:0] addr;
  logic [11:0] lo_lim, hi_lim;
  logic        sel, a32, burst_err;
  logic [1:0]  cls;
  logic [31:0] cur_addr;
  int          n_chk = 0, n_fail = 0, cycles = 0;

  always #2 clk = ~clk;

  am_window_dec u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .am(am), .addr(addr),
    .lo_lim(lo_lim), .hi_lim(hi_lim), .port_dis(port_dis), .beat(beat),
    .sel(sel), .cls(cls), .a32(a32), .cur_addr(cur_addr), .burst_err(burst_err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic start_cyc(logic [5:0] m, logic [31:0] a);
    am = m; addr = a; cyc_start = 1'b1;
    step();
    cyc_start = 1'b0;
  endtask

  task automatic beats(int n);
    beat = 1'b1;
    for (int i = 0; i < n; i++) step();
    beat = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 reset sel", {31'b0, sel}, 32'd0);
    check("R12 reset cls", {30'b0, cls}, 32'd0);
    check("R12 reset err", {31'b0, burst_err}, 32'd0);
  endtask

  task automatic t_classes();
    logic [2:0] lo3;
    logic [1:0] ec;
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < 8; k++) begin
        lo3 = 3'(k);
        ec = (lo3 == 0 || lo3 == 4) ? 2'd3 : (lo3 == 3 || lo3 == 7) ? 2'd2 : 2'd1;
        start_cyc(g ? {3'b001, lo3} : {3'b111, lo3}, 32'h0010_0000);
        if (g) begin
          check("R2 class", {30'b0, cls}, {30'b0, ec});
          check("R2 a32", {31'b0, a32}, 32'd1);
        end else begin
          check("R1 class", {30'b0, cls}, {30'b0, ec});
          check("R1 a32", {31'b0, a32}, 32'd0);
        end
      end
    end
  endtask

  task automatic t_bad_am();
    start_cyc(6'h29, 32'h0010_0000);
    check("R3 sel", {31'b0, sel}, 32'd0);
    check("R3 cls", {30'b0, cls}, 32'd0);
    start_cyc(6'h3D, 32'h0010_0000);
    start_cyc(6'h10, 32'h0020_0000);
    check("R3 sel after valid", {31'b0, sel}, 32'd0);
  endtask

  task automatic t_window();
    start_cyc(6'h0D, 32'h0010_0000);
    check("R4 lower inclusive", {31'b0, sel}, 32'd1);
    start_cyc(6'h0D, 32'h000F_FFFC);
    check("R4 below lower", {31'b0, sel}, 32'd0);
    start_cyc(6'h0D, 32'h002F_FFFC);
    check("R4 top of window", {31'b0, sel}, 32'd1);
    start_cyc(6'h0D, 32'h0030_0000);
    check("R4 upper exclusive", {31'b0, sel}, 32'd0);
    start_cyc(6'h0D, 32'hAB10_0000);
    check("R4 high bits count", {31'b0, sel}, 32'd0);
  endtask

  task automatic t_a24();
    start_cyc(6'h39, 32'hAB12_3450);
    check("R5 a24 masked sel", {31'b0, sel}, 32'd1);
    check("R5 a24 cur_addr", cur_addr, 32'h0012_3450);
  endtask

  task automatic t_blt();
    start_cyc(6'h0B, 32'h0010_0100);
    beats(1);
    check("R7 blt step 4", cur_addr, 32'h0010_0104);
    beats(63);
    check("R8 64 beats ok addr", cur_addr, 32'h0010_0200);
    check("R8 64 beats no err", {31'b0, burst_err}, 32'd0);
    beats(1);
    check("R8 65th err", {31'b0, burst_err}, 32'd1);
    check("R8 65th addr held", cur_addr, 32'h0010_0200);
    step();
    check("R10 err sticky", {31'b0, burst_err}, 32'd1);
    start_cyc(6'h0B, 32'h0020_0000);
    check("R10 start clears err", {31'b0, burst_err}, 32'd0);
    check("R10 start loads addr", cur_addr, 32'h0020_0000);
  endtask

  task automatic t_mblt();
    start_cyc(6'h3C, 32'h0010_0000);
    beats(1);
    check("R7 mblt step 8", cur_addr, 32'h0010_0008);
    beats(255);
    check("R9 256 beats addr", cur_addr, 32'h0010_0800);
    check("R9 256 beats no err", {31'b0, burst_err}, 32'd0);
    beats(1);
    check("R9 257th err", {31'b0, burst_err}, 32'd1);
    check("R9 257th addr held", cur_addr, 32'h0010_0800);
  endtask

  task automatic t_start_vs_beat();
    start_cyc(6'h0F, 32'h0010_0000);
    beats(4);
    am = 6'h0F; addr = 32'h0020_0040; cyc_start = 1'b1; beat = 1'b1;
    step();
    cyc_start = 1'b0; beat = 1'b0;
    check("R10 start wins addr", cur_addr, 32'h0020_0040);
    check("R10 start wins err", {31'b0, burst_err}, 32'd0);
    beats(1);
    check("R10 count restarted", cur_addr, 32'h0020_0044);
  endtask

  task automatic t_disable();
    port_dis = 1'b1;
    start_cyc(6'h0D, 32'h0010_0000);
    check("R6 dis at start", {31'b0, sel}, 32'd0);
    port_dis = 1'b0;
    start_cyc(6'h0B, 32'h0010_0000);
    beats(2);
    check("R6 pre-disable sel", {31'b0, sel}, 32'd1);
    port_dis = 1'b1; beat = 1'b1;
    step();
    check("R6 sel drops", {31'b0, sel}, 32'd0);
    step(); step();
    beat = 1'b0;
    check("R6 beats ignored", cur_addr, 32'h0010_0008);
    port_dis = 1'b0;
    step();
    check("R6 stays low", {31'b0, sel}, 32'd0);
  endtask

  task automatic t_idle_beats();
    start_cyc(6'h09, 32'h0010_0020);
    beats(70);
    check("R11 single beats addr", cur_addr, 32'h0010_0020);
    check("R11 single beats err", {31'b0, burst_err}, 32'd0);
    start_cyc(6'h0B, 32'h0050_0000);
    beats(70);
    check("R11 unclaimed addr", cur_addr, 32'h0050_0000);
    check("R11 unclaimed err", {31'b0, burst_err}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cyc_start = 1'b0; port_dis = 1'b0; beat = 1'b0;
    am = 6'h00; addr = '0; lo_lim = 12'd1; hi_lim = 12'd3;
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_classes();
    t_bad_am();
    t_window();
    t_a24();
    t_blt();
    t_mblt();
    t_start_vs_beat();
    t_disable();
    t_idle_beats();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule